// File: doc/BRIEF.md
# Autoincrementing Indirect Host Access Port

This block gives a 16-bit host a narrow indirect path into a 32-bit local memory bus. The host first loads a 32-bit target address through two 16-bit address registers (low and high halves), then reads or writes a single data port repeatedly. Each data-port access presents the stored address on the local word-address lines, asserts the active-low local chip select, and moves 16 bits between the host and one half of a 32-bit local data latch. A half pointer alternates lower and upper halves, and the address moves on by one 32-bit word once the upper half has been handled.

Three configuration inputs choose the stepping behaviour. With the increment enable set, the port either steps on every access or only on writes, and the chip select stays asserted between data accesses. With it clear, the port still steps but drops the chip select between accesses. Combinations outside the allowed set raise a mode-error flag and freeze the half pointer and address. An enable input selects this indirect port. While it is low, the port ignores the host and the memory-mapped path is reported as active.

Top module: `hip_indirect_port`

## Requirements
- R1: After reset the chip select output `loc_cs_n` is 1, `loc_we` is 0, both address registers read back 0, and the half pointer is on the lower half.
- R2: With `host_ofs`=0 a host write loads address bits 15:0, and with `host_ofs`=1 it loads bits 31:16. A read at the same offsets returns those bits. Either write resets the half pointer to the lower half.
- R3: A data-port access (`host_ofs`=2) while the port is enabled drives the address held before that access, bits 31:5, onto `loc_addr` and drives `loc_cs_n` to 0 on the following clock edge.
- R4: A data-port write copies `host_wdata` into bits 15:0 of `loc_wdata` when the half pointer is 0, or into bits 31:16 when it is 1. It pulses `loc_we` high for one cycle and reports the half used on `loc_half`. Any other cycle leaves `loc_we` at 0.
- R5: A data-port read returns `loc_rdata[15:0]` when the half pointer is 0 and `loc_rdata[31:16]` when it is 1.
- R6: In a valid mode with `cfg_ai_wr`=0, every data access flips the half pointer. An access on the upper half also adds 32 to the stored address, and an address readback returns the next address.
- R7: In a valid mode with `cfg_ai_wr`=1, a data read flips the half pointer and never changes the address. A data write on the upper half adds 32 to the address.
- R8: A read or write of either address register forces `loc_cs_n` to 1 on the next edge.
- R9: With `inc_en`=0, `loc_cs_n` returns to 1 at the end of any cycle that is not a data access.
- R10: `mode_err` is 1 exactly when `inc_en`=1 and `cfg_pfw`≠`cfg_ai_wr`. While it is 1, data accesses still reach the local bus, but the half pointer and the address do not change.
- R11: While `port_en`=0, host accesses change no register, `loc_cs_n` is 1, `host_rdata` is 0, and `mem_map_en` is 1. `mem_map_en` is 0 while `port_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Enables the indirect port |
| inc_en | input | 1 | Increment enable; keeps chip select asserted between data accesses |
| cfg_pfw | input | 1 | Prefetch-on-write setting; must equal cfg_ai_wr when inc_en is 1 |
| cfg_ai_wr | input | 1 | 1: step only on writes, 0: step on every access |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_ofs | input | 2 | Register offset: 0 address low, 1 address high, 2 data |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| loc_addr | output | 27 | Local word address, bits 31:5 |
| loc_cs_n | output | 1 | Local chip select, active low |
| loc_wdata | output | 32 | Local write data latch |
| loc_we | output | 1 | One-cycle local write pulse |
| loc_half | output | 1 | Half used by the last data access |
| loc_rdata | input | 32 | Local read data |
| mem_map_en | output | 1 | Memory-mapped path active |
| mode_err | output | 1 | Undefined mode combination selected |

## Verification
The hardest state to reach from the ports is a write-only stepping mode in which reads have left the half pointer on the upper half, so that the next write both fills the upper half and advances the address. Directed sequences set this up with an odd number of reads followed by a write and an address readback. Random stimulus then mixes all eight mode combinations, port disables and all four offsets, so that mid-stream mode changes and undefined modes meet a half pointer in either position.

// File: rtl/hip_pkg.sv
package hip_pkg;
  parameter int HOST_W   = 16;
  parameter int ADDR_W   = 2 * HOST_W;
  parameter int WORD_LSB = 5;
  localparam int LOC_W   = 2 * HOST_W;
  localparam int LADDR_W = ADDR_W - WORD_LSB;

  typedef logic [HOST_W-1:0] hword_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    OFS_ADDR_LO = 2'd0,
    OFS_ADDR_HI = 2'd1,
    OFS_DATA    = 2'd2,
    OFS_RSVD    = 2'd3
  } port_ofs_e;

  // Next local word address: one 32-bit word further on.
  function automatic addr_t word_step(input addr_t a);
    return a + (addr_t'(1) << WORD_LSB);
  endfunction

  // Undefined when increment is on and the two trigger bits disagree.
  function automatic logic bad_mode(input logic inc, input logic pfw, input logic ai);
    return inc & (pfw ^ ai);
  endfunction
endpackage

// File: rtl/hip_mode_dec.sv
module hip_mode_dec
  import hip_pkg::*;
(
  input  logic inc_en,
  input  logic cfg_pfw,
  input  logic cfg_ai_wr,
  output logic mode_ok,
  output logic trig_all,
  output logic mode_err
);
  assign mode_err = bad_mode(inc_en, cfg_pfw, cfg_ai_wr);
  assign mode_ok  = ~mode_err;
  assign trig_all = ~cfg_ai_wr;

  always_comb begin
    AST_ERR_MATCHES_BITS: assert (mode_err == (inc_en && (cfg_pfw != cfg_ai_wr))); // R10
  end
endmodule

// File: rtl/hip_addr_regs.sv
module hip_addr_regs
  import hip_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_lo,
  input  logic   ld_hi,
  input  hword_t wdata,
  input  logic   data_acc,
  input  logic   is_wr,
  input  logic   mode_ok,
  input  logic   trig_all,
  output addr_t  addr,
  output logic   half
);
  logic step_half;
  logic step_addr;

  assign step_half = data_acc & mode_ok;
  assign step_addr = step_half & half & (trig_all | is_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      half <= 1'b0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) addr[HOST_W-1:0]      <= wdata;
      if (ld_hi) addr[ADDR_W-1:HOST_W] <= wdata;
      half <= 1'b0;
    end else begin
      if (step_addr) addr <= word_step(addr);
      if (step_half) half <= ~half;
    end
  end

  AST_LOAD_CLEARS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo || ld_hi) |=> !half); // R2
  AST_BAD_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !mode_ok) |=> ($stable(half) && $stable(addr))); // R10
  AST_READ_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !is_wr && !trig_all) |=> $stable(addr)); // R7
  AST_LOWER_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !half) |=> $stable(addr)); // R6
endmodule

// File: rtl/hip_loc_side.sv
module hip_loc_side
  import hip_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               inc_en,
  input  logic               data_acc,
  input  logic               areg_acc,
  input  logic               is_wr,
  input  addr_t              addr,
  input  logic               half,
  input  hword_t             wdata,
  output logic [LADDR_W-1:0] loc_addr,
  output logic               loc_cs_n,
  output logic [LOC_W-1:0]   loc_wdata,
  output logic               loc_we,
  output logic               loc_half
);
  localparam int NHALF = LOC_W / HOST_W;

  logic                          wr_hit;
  logic [NHALF-1:0][HOST_W-1:0]  lat_nxt;

  assign wr_hit = data_acc & is_wr;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign lat_nxt[h] = (wr_hit && (32'(half) == h)) ? wdata
                                                      : loc_wdata[h*HOST_W +: HOST_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_addr  <= '0;
      loc_cs_n  <= 1'b1;
      loc_wdata <= '0;
      loc_we    <= 1'b0;
      loc_half  <= 1'b0;
    end else begin
      loc_we    <= wr_hit;
      loc_wdata <= lat_nxt;
      if (data_acc) begin
        loc_addr <= addr[ADDR_W-1:WORD_LSB];
        loc_half <= half;
      end
      if (!port_en || areg_acc) loc_cs_n <= 1'b1;
      else if (data_acc)        loc_cs_n <= 1'b0;
      else if (!inc_en)         loc_cs_n <= 1'b1;
    end
  end

  AST_CS_LOW_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> !loc_cs_n); // R3
  AST_CS_HIGH_ON_AREG: assert property (@(posedge clk) disable iff (!rst_n)
    areg_acc |=> loc_cs_n); // R8
  AST_NOINC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !data_acc) |=> loc_cs_n); // R9
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (loc_cs_n && !loc_we)); // R11
  AST_WE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !loc_we); // R4
endmodule

// File: rtl/hip_indirect_port.sv
module hip_indirect_port
  import hip_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               inc_en,
  input  logic               cfg_pfw,
  input  logic               cfg_ai_wr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [1:0]         host_ofs,
  input  logic [HOST_W-1:0]  host_wdata,
  output logic [HOST_W-1:0]  host_rdata,
  output logic [LADDR_W-1:0] loc_addr,
  output logic               loc_cs_n,
  output logic [LOC_W-1:0]   loc_wdata,
  output logic               loc_we,
  output logic               loc_half,
  input  logic [LOC_W-1:0]   loc_rdata,
  output logic               mem_map_en,
  output logic               mode_err
);
  port_ofs_e ofs;
  logic      any_acc, data_acc, areg_acc, ld_lo, ld_hi;
  logic      mode_ok, trig_all, half;
  addr_t     addr;

  assign ofs      = port_ofs_e'(host_ofs);
  assign any_acc  = port_en & (host_rd | host_wr);
  assign data_acc = any_acc & (ofs == OFS_DATA);
  assign areg_acc = any_acc & ((ofs == OFS_ADDR_LO) | (ofs == OFS_ADDR_HI));
  assign ld_lo    = port_en & host_wr & (ofs == OFS_ADDR_LO);
  assign ld_hi    = port_en & host_wr & (ofs == OFS_ADDR_HI);
  assign mem_map_en = ~port_en;

  hip_mode_dec u_mode (
    .inc_en    (inc_en),
    .cfg_pfw   (cfg_pfw),
    .cfg_ai_wr (cfg_ai_wr),
    .mode_ok   (mode_ok),
    .trig_all  (trig_all),
    .mode_err  (mode_err)
  );

  hip_addr_regs u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .wdata    (host_wdata),
    .data_acc (data_acc),
    .is_wr    (host_wr),
    .mode_ok  (mode_ok),
    .trig_all (trig_all),
    .addr     (addr),
    .half     (half)
  );

  hip_loc_side u_loc (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .inc_en    (inc_en),
    .data_acc  (data_acc),
    .areg_acc  (areg_acc),
    .is_wr     (host_wr),
    .addr      (addr),
    .half      (half),
    .wdata     (host_wdata),
    .loc_addr  (loc_addr),
    .loc_cs_n  (loc_cs_n),
    .loc_wdata (loc_wdata),
    .loc_we    (loc_we),
    .loc_half  (loc_half)
  );

  always_comb begin
    host_rdata = '0;
    if (port_en) begin
      unique case (ofs)
        OFS_ADDR_LO: host_rdata = addr[HOST_W-1:0];
        OFS_ADDR_HI: host_rdata = addr[ADDR_W-1:HOST_W];
        OFS_DATA:    host_rdata = half ? loc_rdata[LOC_W-1:HOST_W] : loc_rdata[HOST_W-1:0];
        default:     host_rdata = '0;
      endcase
    end
  end

  always_comb begin
    AST_DISABLED_QUIET: assert (port_en || (host_rdata == '0 && mem_map_en)); // R11
  end
endmodule

// File: tb/tb_hip_indirect_port.sv
module tb_hip_indirect_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b1, inc_en = 1'b0, cfg_pfw = 1'b0, cfg_ai_wr = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_ofs = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic [26:0] loc_addr;
  logic        loc_cs_n, loc_we, loc_half, mem_map_en, mode_err;
  logic [31:0] loc_wdata;
  logic [31:0] loc_rdata = 32'h0;

  int checks = 0, fails = 0;
  logic [31:0] m_addr = 32'h0, m_lat = 32'h0;
  logic        m_half = 1'b0, m_cs_n = 1'b1;
  logic [15:0] last_rd;

  always #5 clk = ~clk;

  hip_indirect_port dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .inc_en(inc_en),
    .cfg_pfw(cfg_pfw), .cfg_ai_wr(cfg_ai_wr), .host_rd(host_rd),
    .host_wr(host_wr), .host_ofs(host_ofs), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .loc_addr(loc_addr), .loc_cs_n(loc_cs_n),
    .loc_wdata(loc_wdata), .loc_we(loc_we), .loc_half(loc_half),
    .loc_rdata(loc_rdata), .mem_map_en(mem_map_en), .mode_err(mode_err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic undefined_mode(input logic i, input logic p, input logic a);
    return (i == 1'b1) && (p != a);
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] o);
    if (!port_en) return 16'h0;
    case (o)
      2'd0: return m_addr[15:0];
      2'd1: return m_addr[31:16];
      2'd2: return m_half ? loc_rdata[31:16] : loc_rdata[15:0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic op(input logic rd, input logic wr, input logic [1:0] o, input logic [15:0] d);
    logic acc, dat, areg, bad;
    logic [15:0] er;
    string rtag;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_ofs = o; host_wdata = d;
    #1;
    er = exp_read(o);
    bad = undefined_mode(inc_en, cfg_pfw, cfg_ai_wr);
    rtag = !port_en ? "R11" : (o == 2'd2 ? "R5" : "R2");
    if (rd) begin
      last_rd = host_rdata;
      chk(host_rdata == er, rtag, 32'(host_rdata), 32'(er));
    end
    chk(mode_err == bad, "R10", 32'(mode_err), 32'(bad));
    chk(mem_map_en == !port_en, "R11", 32'(mem_map_en), 32'(!port_en));
    acc  = port_en && (rd || wr);
    dat  = acc && (o == 2'd2);
    areg = acc && (o < 2'd2);
    @(posedge clk); #1;
    host_rd = 1'b0; host_wr = 1'b0;
    if (dat) begin
      chk(loc_addr == m_addr[31:5], "R3", 32'(loc_addr), 32'(m_addr[31:5]));
      chk(loc_half == m_half, "R4", 32'(loc_half), 32'(m_half));
      if (wr) begin
        if (m_half) m_lat[31:16] = d; else m_lat[15:0] = d;
      end
    end
    chk(loc_we == (dat && wr), "R4", 32'(loc_we), 32'(dat && wr));
    chk(loc_wdata == m_lat, "R4", loc_wdata, m_lat);
    if (!port_en || areg) m_cs_n = 1'b1;
    else if (dat)         m_cs_n = 1'b0;
    else if (!inc_en)     m_cs_n = 1'b1;
    chk(loc_cs_n == m_cs_n,
        !port_en ? "R11" : areg ? "R8" : dat ? "R3" : !inc_en ? "R9" : "R3",
        32'(loc_cs_n), 32'(m_cs_n));
    if (areg && wr) begin
      if (o == 2'd0) m_addr[15:0] = d; else m_addr[31:16] = d;
      m_half = 1'b0;
    end
    if (dat && !bad) begin
      if (m_half && (!cfg_ai_wr || wr)) m_addr = m_addr + 32'd32;
      m_half = ~m_half;
    end
  endtask

  task automatic set_mode(input logic i, input logic p, input logic a);
    @(negedge clk);
    inc_en = i; cfg_pfw = p; cfg_ai_wr = a;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(loc_cs_n == 1'b1, "R1", 32'(loc_cs_n), 1);
    chk(loc_we == 1'b0, "R1", 32'(loc_we), 0);
    op(1, 0, 2'd0, 0);
    chk(last_rd == 16'h0, "R1", 32'(last_rd), 0);
    op(1, 0, 2'd1, 0);
    chk(last_rd == 16'h0, "R1", 32'(last_rd), 0);

    // R2 / R6 every-access stepping
    set_mode(1, 0, 0);
    op(0, 1, 2'd0, 16'h0040);
    op(0, 1, 2'd1, 16'h1234);
    op(1, 0, 2'd1, 0);
    chk(last_rd == 16'h1234, "R2", 32'(last_rd), 32'h1234);
    op(0, 1, 2'd2, 16'h00A1);
    op(0, 1, 2'd2, 16'h00B2);
    chk(loc_wdata == 32'h00B2_00A1, "R4", loc_wdata, 32'h00B2_00A1);
    op(0, 1, 2'd2, 16'h00C3);
    chk(loc_addr == 27'(32'h1234_0060 >> 5), "R6", 32'(loc_addr), 32'h1234_0060 >> 5);
    op(0, 1, 2'd2, 16'h00D4);
    op(1, 0, 2'd0, 0);
    chk(last_rd == 16'h0080, "R6", 32'(last_rd), 32'h80);

    // R7 write-only stepping, R5 half alternation
    set_mode(1, 1, 1);
    loc_rdata = 32'hDEAD_BEEF;
    op(0, 1, 2'd0, 16'h0000);
    op(0, 1, 2'd1, 16'h0001);
    op(1, 0, 2'd2, 0);
    chk(last_rd == 16'hBEEF, "R5", 32'(last_rd), 32'hBEEF);
    op(1, 0, 2'd2, 0);
    chk(last_rd == 16'hDEAD, "R5", 32'(last_rd), 32'hDEAD);
    op(1, 0, 2'd2, 0);
    chk(loc_addr == 27'(32'h0001_0000 >> 5), "R7", 32'(loc_addr), 32'h0001_0000 >> 5);
    op(1, 0, 2'd0, 0);
    chk(last_rd == 16'h0000, "R7", 32'(last_rd), 0);
    op(0, 1, 2'd2, 16'h5555);
    op(1, 0, 2'd0, 0);
    chk(last_rd == 16'h0020, "R7", 32'(last_rd), 32'h20);

    // R10 undefined combination freezes stepping
    set_mode(1, 1, 0);
    op(0, 1, 2'd0, 16'h0000);
    op(0, 1, 2'd2, 16'h1111);
    op(0, 1, 2'd2, 16'h2222);
    chk(loc_half == 1'b0, "R10", 32'(loc_half), 0);
    op(1, 0, 2'd0, 0);
    chk(last_rd == 16'h0000, "R10", 32'(last_rd), 0);

    // R9 chip select released without increment enable
    set_mode(0, 0, 0);
    op(0, 1, 2'd2, 16'h3333);
    chk(loc_cs_n == 1'b0, "R9", 32'(loc_cs_n), 0);
    op(0, 0, 2'd2, 0);
    chk(loc_cs_n == 1'b1, "R9", 32'(loc_cs_n), 1);

    // R11 disabled port ignores writes
    @(negedge clk); port_en = 1'b0;
    op(0, 1, 2'd0, 16'hFFFF);
    op(0, 1, 2'd2, 16'hFFFF);
    @(negedge clk); port_en = 1'b1;
    op(1, 0, 2'd0, 0);
    chk(last_rd == m_addr[15:0], "R11", 32'(last_rd), 32'(m_addr[15:0]));

    // random mix against the bench model
    for (int n = 0; n < 1500; n++) begin
      if (n % 23 == 0) set_mode(1'($urandom), 1'($urandom), 1'($urandom));
      @(negedge clk);
      port_en   = ($urandom % 10) != 0;
      loc_rdata = $urandom;
      begin
        int k = $urandom % 8;
        logic [1:0] o = (k < 5) ? 2'd2 : 2'($urandom);
        logic rw = 1'($urandom);
        if (k == 7) op(0, 0, o, 16'($urandom));
        else        op(!rw, rw, o, 16'($urandom));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule